// File: doc/BRIEF.md
# Dual-Rail Power-On Reset Sequencer

This block produces the active-low system reset for a circuit fed by two supply rails, a core rail and an I/O rail. Two threshold comparators outside the block watch the rails, and each gives the block a digital "rail good" flag. The block runs from a free-running clock with a fixed period. Every time value is a count of clock cycles, set by a parameter.

Release follows a fixed order. The core flag must go good first. That starts a power-up delay, and reset stays low while it runs. The I/O flag is examined only when the delay ends. Reset is released only if both flags are good at that moment. Once the block is running, a rail failure causes reset only if the low lasts longer than a reaction window; shorter lows are filtered out. A two-bit timing select sets a fast or slow delay. The watchdog-off setting also uses the slow delay. A watchdog can request a reset at any time, and the full delay then runs again. Each release produces a one-cycle pulse, which the watchdog uses to start its own windows. All pins are plain control and status signals, so no handshake applies.

Top module: `por_sequencer`

## Requirements
- R1: While `rst_n` is low, and afterwards until a release, `rst_out_n` is 0 and `rel_pulse` is 0.
- R2: From the first clock edge that samples `core_ok` high while reset is waiting, `rst_out_n` stays 0 for exactly the selected delay (DLY cycles). It goes 1 at edge DLY if `io_ok` is 1 there.
- R3: `tsel` is sampled on the edge that starts a delay. A value of 2'b10 or 2'b11 selects FAST_CYC. A value of 2'b01 selects SLOW_CYC. A value of 2'b00 (watchdog off) also selects SLOW_CYC.
- R4: If `io_ok` is 0 on the edge where the delay ends, reset stays 0. A new full delay starts on the first edge that sees both flags at 1.
- R5: `io_ok` is ignored while the delay runs. A low on `io_ok` during the delay, with the flag back at 1 when the delay ends, does not move the release.
- R6: If `core_ok` drops during the delay, the delay is abandoned. A fresh full delay starts when `core_ok` is 1 again, and no release happens at the old end time.
- R7: While released, a low on either flag that lasts REACT_CYC consecutive samples or fewer leaves `rst_out_n` at 1.
- R8: While released, a low on either flag that reaches REACT_CYC+1 consecutive samples drives `rst_out_n` to 0 right after that sample's edge.
- R9: `rel_pulse` is 1 for exactly the one cycle in which `rst_out_n` changes from 0 to 1, and at no other time.
- R10: If `wd_req` is sampled at 1 while released, `rst_out_n` goes 0 on that edge. The full delay then reruns, and the release comes DLY cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| core_ok | input | 1 | Core rail at or above its threshold |
| io_ok | input | 1 | I/O rail at or above its threshold |
| tsel | input | 2 | Timing select: 00 off/slow, 01 slow, 1x fast |
| wd_req | input | 1 | Watchdog reset request |
| rst_out_n | output | 1 | Active-low system reset |
| rel_pulse | output | 1 | One-cycle pulse when reset is released |

## Verification
Release timing is tested in several ways: both flags rising together, watchdog-triggered reruns, and each of the four timing-select codes. These runs show that the delay length is chosen correctly and that it counts from the correct edge. The failure paths use lows on each rail separately: lows exactly at the reaction limit and lows one sample longer. These runs test the filter boundary. Three further patterns cover the ordering rules: an I/O flag still low when the delay ends, an I/O flag that dips only in mid-delay, and a core flag dropped during the delay. These separate the correct behaviour from a design that checks I/O too early, continues a delay it should abandon, or releases as soon as the I/O flag recovers.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_CORE = 2'd0,
    ST_DELAY     = 2'd1,
    ST_WAIT_BOTH = 2'd2,
    ST_RUN       = 2'd3
  } por_state_t;

  localparam int unsigned NRAIL = 2;

  // 1x: fast timing; 01 and 00 (watchdog off): slow timing
  function automatic logic tsel_is_fast(input logic [1:0] sel);
    case (sel)
      2'b10, 2'b11: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/por_rail_filter.sv
module por_rail_filter #(
  parameter int unsigned REACT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  output logic fail_o
);
  localparam int unsigned RW = $clog2(REACT_CYC + 1);

  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (ok_i) begin
      low_run <= '0;
    end else if (low_run != RW'(REACT_CYC)) begin
      low_run <= low_run + 1'b1;
    end
  end

  // fires on the low sample that follows REACT_CYC earlier low samples
  assign fail_o = !ok_i && (low_run == RW'(REACT_CYC));
endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
  parameter int unsigned FAST_CYC = 800000,
  parameter int unsigned SLOW_CYC = 3200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] tsel_i,
  output logic       expired_o
);
  localparam int unsigned MAXC = (FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= CW'(MAXC);
    end else if (start_i) begin
      cnt <= '0;
      lim <= por_pkg::tsel_is_fast(tsel_i) ? CW'(FAST_CYC) : CW'(SLOW_CYC);
    end else if (cnt != lim) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired_o = (cnt == lim - CW'(1));
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int unsigned FAST_CYC  = 800000,
  parameter int unsigned SLOW_CYC  = 3200000,
  parameter int unsigned REACT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_ok,
  input  logic       io_ok,
  input  logic [1:0] tsel,
  input  logic       wd_req,
  output logic       rst_out_n,
  output logic       rel_pulse
);
  import por_pkg::*;

  por_state_t       state, nxt;
  logic             start;
  logic             expired;
  logic [NRAIL-1:0] rail_ok;
  logic [NRAIL-1:0] rail_fail;
  logic             fail_any;

  assign rail_ok = {io_ok, core_ok};

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    por_rail_filter #(.REACT_CYC(REACT_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .ok_i  (rail_ok[g]),
      .fail_o(rail_fail[g])
    );
  end

  assign fail_any = |rail_fail;

  por_delay_timer #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .tsel_i   (tsel),
    .expired_o(expired)
  );

  always_comb begin
    nxt   = state;
    start = 1'b0;
    unique case (state)
      ST_WAIT_CORE: begin
        if (core_ok) begin
          nxt   = ST_DELAY;
          start = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!core_ok) begin
          nxt = ST_WAIT_CORE;
        end else if (wd_req) begin
          start = 1'b1;
        end else if (expired) begin
          nxt = io_ok ? ST_RUN : ST_WAIT_BOTH;
        end
      end
      ST_WAIT_BOTH: begin
        if (core_ok && io_ok) begin
          nxt   = ST_DELAY;
          start = 1'b1;
        end
      end
      ST_RUN: begin
        if (fail_any) begin
          nxt = ST_WAIT_CORE;
        end else if (wd_req) begin
          nxt   = ST_DELAY;
          start = 1'b1;
        end
      end
      default: nxt = ST_WAIT_CORE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT_CORE;
      rst_out_n <= 1'b0;
      rel_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      rst_out_n <= (nxt == ST_RUN);
      rel_pulse <= (nxt == ST_RUN) && (state != ST_RUN);
    end
  end
endmodule

// File: rtl/por_sequencer_chk.sv
module por_sequencer_chk #(
  parameter int unsigned REACT_CYC = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic core_ok,
  input logic io_ok,
  input logic wd_req,
  input logic rst_out_n,
  input logic rel_pulse
);
  localparam int unsigned RW = $clog2(REACT_CYC + 1);

  logic [RW-1:0] lc, li;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc <= '0;
      li <= '0;
    end else begin
      if (core_ok) lc <= '0;
      else if (lc != RW'(REACT_CYC)) lc <= lc + 1'b1;
      if (io_ok) li <= '0;
      else if (li != RW'(REACT_CYC)) li <= li + 1'b1;
    end
  end

  assert_core_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && !core_ok) |=> !rst_out_n);

  assert_io_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && !io_ok) |=> !rst_out_n);

  assert_short_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !wd_req && (core_ok || lc < RW'(REACT_CYC))
                           && (io_ok   || li < RW'(REACT_CYC))) |=> rst_out_n);

  assert_long_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && ((!core_ok && lc == RW'(REACT_CYC)) ||
                   (!io_ok   && li == RW'(REACT_CYC)))) |=> !rst_out_n);

  assert_wd_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && wd_req) |=> !rst_out_n);

  assert_pulse_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> (rst_out_n && !$past(rst_out_n)));

  assert_rise_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> rel_pulse);
endmodule

bind por_sequencer por_sequencer_chk #(.REACT_CYC(REACT_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .core_ok  (core_ok),
  .io_ok    (io_ok),
  .wd_req   (wd_req),
  .rst_out_n(rst_out_n),
  .rel_pulse(rel_pulse)
);

// File: tb/sim_por_sequencer.sv
module sim_por_sequencer;
  localparam int DF = 20;
  localparam int DS = 50;
  localparam int RC = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       core_ok, io_ok, wd_req;
  logic [1:0] tsel;
  logic       rst_out_n, rel_pulse;

  int cyc = 0;
  int n_total = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    rst;
    bit    pls;
    string req;
  } exp_t;

  exp_t sbq[$];

  por_sequencer #(.FAST_CYC(DF), .SLOW_CYC(DS), .REACT_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .core_ok(core_ok), .io_ok(io_ok),
    .tsel(tsel), .wd_req(wd_req), .rst_out_n(rst_out_n), .rel_pulse(rel_pulse)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int d, input bit r, input bit p, input string req);
    exp_t e;
    e.at = cyc + d; e.rst = r; e.pls = p; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_now(input string req, input bit act, input bit expv);
    n_total++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, expv);
    end
  endtask

  // monitor: pops scheduled expectations and compares outputs
  always @(negedge clk) begin : mon
    exp_t e;
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      e = sbq.pop_front();
      n_total++;
      if (e.at != cyc) begin
        n_fail++;
        $display("FAIL %s: missed sample at cycle %0d (now %0d)", e.req, e.at, cyc);
      end else if (rst_out_n !== e.rst || rel_pulse !== e.pls) begin
        n_fail++;
        $display("FAIL %s: cycle %0d actual rst=%0b pulse=%0b expected rst=%0b pulse=%0b",
                 e.req, cyc, rst_out_n, rel_pulse, e.rst, e.pls);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; core_ok = 1'b0; io_ok = 1'b0; tsel = 2'b10; wd_req = 1'b0;
    tick(3);
    check_now("R1", rst_out_n, 1'b0);
    check_now("R1", rel_pulse, 1'b0);
    rst_n = 1'b1;
    expect_at(1, 0, 0, "R1");
    expect_at(3, 0, 0, "R1");
    tick(4);

    // R2: both rails good, fast delay
    core_ok = 1'b1; io_ok = 1'b1;
    expect_at(DF, 0, 0, "R2");
    expect_at(DF + 1, 1, 1, "R2");
    expect_at(DF + 2, 1, 0, "R9");
    tick(DF + 4);

    // R10: watchdog request reruns the delay
    wd_req = 1'b1;
    expect_at(1, 0, 0, "R10");
    expect_at(DF, 0, 0, "R10");
    expect_at(DF + 1, 1, 1, "R10");
    expect_at(DF + 2, 1, 0, "R9");
    tick(1); wd_req = 1'b0;
    tick(DF + 3);

    // R7: core glitch at the limit
    core_ok = 1'b0;
    for (int k = 1; k <= RC + 3; k++) expect_at(k, 1, 0, "R7");
    tick(RC); core_ok = 1'b1;
    tick(4);

    // R7: io glitch at the limit
    io_ok = 1'b0;
    for (int k = 1; k <= RC + 3; k++) expect_at(k, 1, 0, "R7");
    tick(RC); io_ok = 1'b1;
    tick(4);

    // R8: core low one sample beyond the limit
    core_ok = 1'b0;
    expect_at(RC, 1, 0, "R8");
    expect_at(RC + 1, 0, 0, "R8");
    tick(RC + 3);

    // R6 with slow timing (R3 code 01)
    tsel = 2'b01;
    core_ok = 1'b1; tick(10);
    core_ok = 1'b0; tick(5);
    core_ok = 1'b1;
    expect_at(DS - 14, 0, 0, "R6");
    expect_at(DS, 0, 0, "R6");
    expect_at(DS + 1, 1, 1, "R3");
    tick(DS + 3);

    // R3: watchdog-off code uses slow delay
    tsel = 2'b00; wd_req = 1'b1;
    expect_at(DF + 1, 0, 0, "R3");
    expect_at(DS, 0, 0, "R3");
    expect_at(DS + 1, 1, 1, "R3");
    tick(1); wd_req = 1'b0;
    tick(DS + 3);

    // R3: code 11 is fast
    tsel = 2'b11; wd_req = 1'b1;
    expect_at(DF, 0, 0, "R3");
    expect_at(DF + 1, 1, 1, "R3");
    tick(1); wd_req = 1'b0;
    tick(DF + 3);
    tsel = 2'b10;

    // R8 on io, then R4: io still low at the end of the delay
    io_ok = 1'b0;
    expect_at(RC + 1, 0, 0, "R8");
    expect_at(RC + DF + 10, 0, 0, "R4");
    tick(RC + DF + 12);
    io_ok = 1'b1;
    expect_at(DF, 0, 0, "R4");
    expect_at(DF + 1, 1, 1, "R4");
    tick(DF + 3);

    // R5: io dip in mid-delay is ignored
    wd_req = 1'b1;
    expect_at(DF, 0, 0, "R5");
    expect_at(DF + 1, 1, 1, "R5");
    tick(1); wd_req = 1'b0; io_ok = 1'b0;
    tick(8); io_ok = 1'b1;
    tick(DF);
    tick(3);

    done = 1'b1;
    if (sbq.size() != 0) begin
      n_total++;
      n_fail++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", sbq.size());
    end
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule